// File: doc/BRIEF.md
# Serial Transmitter with Write Queue

This block is the transmit half of a memory-mapped serial port. Software pushes bytes into a 64-entry queue by writing the data register. A frame engine pulls bytes from the queue and shifts them out on a single line. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts one period of a baud tick that comes from outside the block.

The frame format, the transmit enable and a transmit soft reset are held in a control register. A status register reports queue full, queue empty and shifter busy as separate flags. The line is fully drained only when the empty flag is set and the busy flag is clear. The status register also carries a sticky flag that records a write to a full queue. A level interrupt is raised while the queue holds fewer entries than a programmable threshold. Clear-to-send is treated as always asserted.

The frame engine is a five-state machine: `S_IDLE`, `S_START`, `S_DATA`, `S_PARITY` and `S_STOP`. It only moves on a baud tick. Its transitions are:
- idle to start, when the transmitter is enabled and the queue holds data (the byte is popped);
- start to data;
- data to parity or to stop, after the last data bit, depending on the parity enable;
- parity to stop;
- stop to start, after the last stop bit, for a back-to-back frame when enabled and data is waiting;
- stop to idle, after the last stop bit, otherwise.

Top module: `utx_top`

## Requirements
- R1: A write to offset 0x00 while the queue is not full and the soft reset is clear stores `bus_wdata[7:0]`. Bytes are transmitted in the order they were written.
- R2: A frame starts with one low bit, followed by the data bits least significant bit first. The count is set by control bits 21:20: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Every bit lasts exactly one baud-tick period.
- R3: Control bit 19 set adds a parity bit after the data. Control bit 18 set makes the parity odd, and clear makes it even, over the transmitted data bits.
- R4: Control bits 17:16 equal to 1 give two high stop bits. Any other value gives one.
- R5: While control bit 12 is clear, no new frame starts, the line stays high and the queue keeps its contents.
- R6: Status at offset 0x0c shows bit 21 set when the queue holds 64 entries, bit 22 set when it is empty, and bit 25 set while a frame is on the line. The transmitter is idle only when bit 22 is 1 and bit 25 is 0.
- R7: A data write while the queue is full is dropped, leaving the queue contents unchanged, and sets status bit 18. Bit 18 stays set until a transmit soft reset.
- R8: While control bit 22 is high, the queue is emptied, the frame engine is held idle with the line high, status bit 18 is cleared and data writes are dropped.
- R9: `tx_irq` is high exactly when control bit 28 is set and the queue count is below bits 15:8 of the register at offset 0x10. That register reads back its written threshold.
- R10: The frame format is captured when a frame starts. Control writes made during a frame apply from the next frame.
- R11: After reset the line is high, `tx_irq` is low, control and threshold read 0 and status reads 0x0040_0000.
- R12: When enabled and data is waiting, the next start bit follows the last stop bit with no idle gap, so 8-bit no-parity one-stop frames start 10 bit periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line, idle high |
| tx_irq | output | 1 | Level transmit interrupt |

## Verification
The assertions take for granted that `baud_tick` is a single-cycle pulse. They also assume that software does not pop or push outside the register interface, so queue motion is caused only by bus writes and ticks.

The bench keeps within these assumptions. It drives ticks as exactly one high cycle in every four. It changes the frame format only while the line is idle, except in the deliberate mid-frame control write. It fills the queue only while transmission is disabled, so the full and overflow cases are reached deterministically.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam logic [7:0] OFS_DATA   = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0c;
    localparam logic [7:0] OFS_THRESH = 8'h10;

    localparam int CB_TX_EN   = 12;
    localparam int CB_STOP_LO = 16;
    localparam int CB_ODD     = 18;
    localparam int CB_PAR_EN  = 19;
    localparam int CB_LEN_LO  = 20;
    localparam int CB_SOFTRST = 22;
    localparam int CB_IRQ_EN  = 28;

    localparam int SB_WERR  = 18;
    localparam int SB_FULL  = 21;
    localparam int SB_EMPTY = 22;
    localparam int SB_BUSY  = 25;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } frame_fmt_t;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd8 - {2'b00, code};
    endfunction

    function automatic logic [7:0] data_mask(input logic [1:0] code);
        return 8'hFF >> code;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = store[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= din;
    end

    // R6: occupancy never exceeds the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7: a push into a full queue without a pop leaves the occupancy as it was
    a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    // R8: flushing empties the queue
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/utx_serializer.sv
module utx_serializer
    import utx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  frame_fmt_t    fmt_in,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          pop,
    output logic          busy,
    output logic          txd
);

    tx_state_e     state_q, state_d;
    frame_fmt_t    fmt_q;
    logic [DW-1:0] shreg_q;
    logic [2:0]    bit_cnt_q;
    logic          stop_cnt_q;
    logic          par_q;
    logic          can_launch, last_data, last_stop, load;

    always_comb begin
        can_launch = tx_en && !fifo_empty && !soft_rst;
        last_data  = ({1'b0, bit_cnt_q} == data_bits(fmt_q.len_code) - 4'd1);
        last_stop  = (state_q == S_STOP) && !(fmt_q.two_stop && !stop_cnt_q);
        load       = baud_tick && can_launch && ((state_q == S_IDLE) || last_stop);
        state_d    = state_q;
        if (baud_tick) begin
            unique case (state_q)
                S_IDLE:   if (can_launch) state_d = S_START;
                S_START:  state_d = S_DATA;
                S_DATA:   if (last_data) state_d = fmt_q.par_en ? S_PARITY : S_STOP;
                S_PARITY: state_d = S_STOP;
                S_STOP:   if (last_stop) state_d = can_launch ? S_START : S_IDLE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            fmt_q      <= '0;
            shreg_q    <= '0;
            bit_cnt_q  <= '0;
            stop_cnt_q <= 1'b0;
            par_q      <= 1'b0;
        end else if (soft_rst) begin
            state_q    <= S_IDLE;
            bit_cnt_q  <= '0;
            stop_cnt_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                shreg_q <= fifo_data;
                fmt_q   <= fmt_in;
                par_q   <= (^(fifo_data & data_mask(fmt_in.len_code))) ^ fmt_in.par_odd;
            end
            if (baud_tick) begin
                stop_cnt_q <= (state_q == S_STOP) && !last_stop;
                if (state_q == S_START) bit_cnt_q <= '0;
                if (state_q == S_DATA) begin
                    shreg_q   <= shreg_q >> 1;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        pop  = load;
        busy = (state_q != S_IDLE);
        unique case (state_q)
            S_START:  txd = 1'b0;
            S_DATA:   txd = shreg_q[0];
            S_PARITY: txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    // R5: a disabled transmitter never leaves idle
    a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !tx_en) |=> (state_q == S_IDLE));

    // R2: bit timing comes only from the tick
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !soft_rst) |=> $stable(state_q));

endmodule

// File: rtl/utx_top.sv
module utx_top
    import utx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int TW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          baud_tick,
    output logic          txd,
    output logic          tx_irq
);

    localparam logic [31:0] CTRL_MASK = (32'h1 << CB_TX_EN) | (32'h3 << CB_STOP_LO) |
        (32'h1 << CB_ODD) | (32'h1 << CB_PAR_EN) | (32'h3 << CB_LEN_LO) |
        (32'h1 << CB_SOFTRST) | (32'h1 << CB_IRQ_EN);

    logic [31:0]   ctrl_q;
    logic [TW-1:0] thresh_q;
    logic          werr_q;
    logic          soft_rst, data_wr;
    logic          fifo_full, fifo_empty, fifo_pop, busy;
    logic [DW-1:0] fifo_dout;
    logic [CW-1:0] fifo_count;
    frame_fmt_t    fmt;

    assign soft_rst = ctrl_q[CB_SOFTRST];
    assign data_wr  = bus_wr && (bus_addr == AW'(OFS_DATA));
    assign fmt      = '{len_code: ctrl_q[CB_LEN_LO +: 2], par_en: ctrl_q[CB_PAR_EN],
                        par_odd: ctrl_q[CB_ODD],
                        two_stop: (ctrl_q[CB_STOP_LO +: 2] == 2'd1)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            thresh_q <= '0;
            werr_q   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == AW'(OFS_CTRL))   ctrl_q   <= bus_wdata & CTRL_MASK;
            if (bus_wr && bus_addr == AW'(OFS_THRESH)) thresh_q <= bus_wdata[8 +: TW];
            if (soft_rst)                              werr_q   <= 1'b0;
            else if (data_wr && fifo_full)             werr_q   <= 1'b1;
        end
    end

    utx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (soft_rst),
        .push  (data_wr && !soft_rst),
        .pop   (fifo_pop),
        .din   (bus_wdata[DW-1:0]),
        .dout  (fifo_dout),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    utx_serializer #(.DW(DW)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .baud_tick  (baud_tick),
        .tx_en      (ctrl_q[CB_TX_EN]),
        .fmt_in     (fmt),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_dout),
        .pop        (fifo_pop),
        .busy       (busy),
        .txd        (txd)
    );

    assign tx_irq = ctrl_q[CB_IRQ_EN] && (32'(fifo_count) < 32'(thresh_q));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_CTRL)) begin
            bus_rdata = ctrl_q;
        end else if (bus_addr == AW'(OFS_THRESH)) begin
            bus_rdata[8 +: TW] = thresh_q;
        end else if (bus_addr == AW'(OFS_STATUS)) begin
            bus_rdata[SB_WERR]  = werr_q;
            bus_rdata[SB_FULL]  = fifo_full;
            bus_rdata[SB_EMPTY] = fifo_empty;
            bus_rdata[SB_BUSY]  = busy;
        end
    end

    // R1: the queue is only drained on a bit boundary
    a_r1_pop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> baud_tick);

    // R8: a held soft reset leaves the engine idle with the line high
    a_r8_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && txd));

endmodule

// File: tb/tb_utx_top.sv
module tb_utx_top;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pe;
        bit         po;
        bit         ts;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        baud_tick = 1'b0;
    logic        txd, tx_irq;

    exp_t q[$];
    int   start_hist[$];
    int   n_vec = 0, n_bad = 0, cyc = 0;
    bit   done = 0;
    int   cur_nb = 8;
    bit   cur_pe = 0, cur_po = 0, cur_ts = 0;

    utx_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
        .txd(txd), .tx_irq(tx_irq)
    );

    initial forever #2 clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input bit irq, input bit srst);
        logic [31:0] w;
        w = '0;
        w[12] = en;
        w[28] = irq;
        w[22] = srst;
        w[21:20] = 2'(8 - cur_nb);
        w[19] = cur_pe;
        w[18] = cur_po;
        w[17:16] = cur_ts ? 2'd1 : 2'd0;
        return w;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send(input logic [7:0] b);
        exp_t e;
        e.d = b; e.nb = cur_nb; e.pe = cur_pe; e.po = cur_po; e.ts = cur_ts;
        q.push_back(e);
        wr(8'h00, {24'h0, b});
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        forever begin
            rd(8'h0c, s);
            if (s[22] && !s[25] && q.size() == 0) break;
        end
        repeat (8) @(negedge clk);
    endtask

    // scoreboard monitor: decodes each frame on the line and compares with the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                exp_t e;
                logic [7:0] got;
                bit ok;
                bit p;
                start_hist.push_back(cyc);
                ok = 1; got = '0;
                @(negedge clk);
                if (txd !== 1'b0) ok = 0;
                if (q.size() == 0) begin
                    check(0, "R1 unexpected frame", 0, 0);
                    e.nb = 8; e.pe = 0; e.ts = 0; e.po = 0; e.d = 0;
                end else e = q.pop_front();
                for (int i = 0; i < e.nb; i++) begin
                    repeat (4) @(negedge clk);
                    got[i] = txd;
                end
                if (got != (e.d & (8'hFF >> (8 - e.nb)))) ok = 0;
                if (e.pe) begin
                    repeat (4) @(negedge clk);
                    p = (^(e.d & (8'hFF >> (8 - e.nb)))) ^ e.po;
                    if (txd !== p) ok = 0;
                end
                repeat (4) @(negedge clk);
                if (txd !== 1'b1) ok = 0;
                if (e.ts) begin
                    repeat (4) @(negedge clk);
                    if (txd !== 1'b1) ok = 0;
                end
                check(ok, "R2/R3/R4 frame", {24'h0, got}, {24'h0, e.d});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(8'h08, s); check(s == 32'h0, "R11 ctrl reset", s, 32'h0);
        rd(8'h0c, s); check(s == 32'h0040_0000, "R11 status reset", s, 32'h0040_0000);
        rd(8'h10, s); check(s == 32'h0, "R11 thresh reset", s, 32'h0);
        check(txd === 1'b1 && tx_irq === 1'b0, "R11 line/irq", {30'h0, txd, tx_irq}, 32'h2);

        // R9 threshold and interrupt
        wr(8'h10, 32'h0000_0400);
        rd(8'h10, s); check(s == 32'h0000_0400, "R9 thresh readback", s, 32'h400);
        wr(8'h08, ctrl_word(0, 1, 0));
        @(negedge clk); check(tx_irq === 1'b1, "R9 irq below thresh", {31'h0, tx_irq}, 32'h1);
        send(8'hA5); send(8'h3C); send(8'h81); send(8'h7E);
        @(negedge clk); check(tx_irq === 1'b0, "R9 irq at thresh", {31'h0, tx_irq}, 32'h0);

        // R5 disabled holds data, line high
        repeat (60) @(negedge clk);
        rd(8'h0c, s);
        check(!s[25] && !s[22] && txd === 1'b1, "R5 disabled hold", s, 32'h0);

        // R12 back-to-back, R1 order
        start_hist.delete();
        wr(8'h08, ctrl_word(1, 1, 0));
        wait_idle();
        check(start_hist.size() == 4 && start_hist[1] - start_hist[0] == 40,
              "R12 start spacing", 32'(start_hist[1] - start_hist[0]), 32'd40);
        rd(8'h0c, s); check(s == 32'h0040_0000, "R6 idle status", s, 32'h0040_0000);
        check(tx_irq === 1'b1, "R9 irq after drain", {31'h0, tx_irq}, 32'h1);

        // R2/R3/R4 formats
        cur_nb = 7; cur_pe = 1; cur_po = 0; cur_ts = 0;
        wr(8'h08, ctrl_word(1, 0, 0)); send(8'h5A); wait_idle();
        cur_nb = 6; cur_pe = 1; cur_po = 1; cur_ts = 1;
        wr(8'h08, ctrl_word(1, 0, 0)); send(8'h2D); wait_idle();
        cur_nb = 5; cur_pe = 0; cur_po = 0; cur_ts = 1;
        wr(8'h08, ctrl_word(1, 0, 0)); send(8'h13); wait_idle();

        // R10 mid-frame format change
        cur_nb = 8; cur_pe = 0; cur_po = 0; cur_ts = 0;
        wr(8'h08, ctrl_word(1, 0, 0)); send(8'hC3);
        forever begin rd(8'h0c, s); if (s[25]) break; end
        check(s[25] == 1'b1, "R6 busy during frame", s, 32'h0200_0000);
        cur_nb = 5; cur_pe = 1; cur_po = 1; cur_ts = 1;
        wr(8'h08, ctrl_word(1, 0, 0));
        wait_idle();
        send(8'h1F); wait_idle();

        // R6/R7 full and overflow
        cur_nb = 8; cur_pe = 0; cur_po = 0; cur_ts = 0;
        wr(8'h08, ctrl_word(0, 0, 0));
        for (int i = 0; i < 64; i++) send(8'(i * 3 + 1));
        rd(8'h0c, s); check(s == 32'h0020_0000, "R6 full status", s, 32'h0020_0000);
        wr(8'h00, 32'hEE);
        rd(8'h0c, s); check(s == 32'h0024_0000, "R7 werr set", s, 32'h0024_0000);
        wr(8'h08, ctrl_word(1, 0, 0));
        wait_idle();
        rd(8'h0c, s); check(s == 32'h0044_0000, "R7 werr sticky", s, 32'h0044_0000);

        // R8 soft reset
        wr(8'h08, ctrl_word(0, 0, 0));
        wr(8'h00, 32'h11); wr(8'h00, 32'h22); wr(8'h00, 32'h33);
        wr(8'h08, ctrl_word(1, 0, 1));
        rd(8'h0c, s); check(s == 32'h0040_0000, "R8 flush and werr clear", s, 32'h0040_0000);
        wr(8'h00, 32'h44);
        rd(8'h0c, s); check(s == 32'h0040_0000, "R8 write dropped", s, 32'h0040_0000);
        check(txd === 1'b1, "R8 line high", {31'h0, txd}, 32'h1);
        wr(8'h08, ctrl_word(1, 0, 0));
        repeat (120) @(negedge clk);
        rd(8'h0c, s); check(s == 32'h0040_0000, "R8 nothing sent", s, 32'h0040_0000);
        check(q.size() == 0, "R1 all frames seen", 32'(q.size()), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule